// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block searches for a reference divider M, a feedback multiplier N and a post-divider code PL that bring a PLL's output as close as possible to a requested frequency. The caller gives the requested output rate and the reference rate, both as integer MHz, and pulses `start`. The block then walks the legal post-divider codes in ascending order. For each code it walks M in ascending order and tries one or two N values, rejecting any candidate that breaks the limits on the phase-detector rate, on N or on the VCO window. It keeps the candidate with the smallest rounding error and stops as soon as the error is zero.

Each quotient the search needs comes from one shared restoring divider, so one candidate costs a few divider passes. At the end the block uses the same divider to compute the output rate that the chosen coefficients give. It returns that rate together with M, N, PL, an exact-match flag and a one-cycle `done` pulse. The caller drives the PLL registers from these results, and it also chooses which rate to request.

Top module: `pll_coef_search`

## Requirements
- R1: After reset, `busy`, `done`, `exact`, `m_out`, `n_out`, `pl_out` and `rate_mhz` are all zero.
- R2: A `start` pulse seen while `busy` is low is accepted, and `busy` is high on the next cycle. A `start` seen while `busy` is high is ignored: it causes no second search and no second `done`, and the result belongs to the first request.
- R3: `done` is high for exactly one cycle, in the cycle where `busy` drops. The result outputs change only together with `done` and hold their values until the next `done`.
- R4: The 4-bit code on `pl_out` selects a post-divide ratio as follows. Codes 0 to 14 give 1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32. The table is not monotonic.
- R5: The internal goal T is twice the requested rate. The VCO goal is T + floor(T/50). The upper VCO limit is 2064 MHz, or the VCO goal when the goal is larger.
- R6: The upper ratio bound is ceil(VCOmax/VCOgoal) and the lower bound is floor(1000/VCOgoal), each clamped to 1..32. Each bound becomes the first code among 0..13 whose ratio is at least the bound, or code 14 when there is none. Codes run from the lower code to the upper code.
- R7: For each code, M runs upward from 1 to 255. When floor(ref/M) < 12, the M loop for that code ends. When floor(ref/M) > 38, that M is skipped. When floor(T·ratio·M/ref) > 255, the M loop ends.
- R8: N candidates run from floor to ceil of T·ratio·M/ref. An N below 8 is skipped, and an N above 255 ends the candidate loop. VCO = floor(ref·N/M) must lie within [1000, raised upper limit].
- R9: A candidate's output is floor((VCO + floor(ratio/2))/ratio) and its error is the absolute difference from T. A candidate replaces the best one only if its error is strictly smaller. An error of zero ends the search at once and sets `exact`.
- R10: When no candidate qualifies, the result is M=255, N=8, PL code 1, and `exact` is 0.
- R11: `rate_mhz` = floor(floor(ref·N/(M·ratio))/2), computed from the returned coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only while idle |
| target_mhz | input | FREQ_W | Requested output rate in MHz |
| ref_mhz | input | FREQ_W | Reference rate in MHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| m_out | output | M_W | Chosen reference divider |
| n_out | output | N_W | Chosen feedback multiplier |
| pl_out | output | 4 | Chosen post-divider code |
| exact | output | 1 | Zero error was reached |
| rate_mhz | output | FREQ_W+2 | Output rate of the chosen coefficients |

## Verification
The search is driven with hand-worked pairs. A low target at a 12 MHz reference shows whether the first exact hit is taken. A very low target pushes both bounds to the last code. A target whose VCO goal exceeds 2064 MHz accepts a VCO that only the raised limit allows. A 77 MHz reference must skip small M values, and its best error of 1 must not be replaced by a later tie. A 10 MHz reference admits no candidate and shows whether the default coefficients come back. A sweep over further reference/target pairs is then compared against a behavioural model of the rules. A request issued mid-search shows whether the block truly ignores start while busy.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

   localparam int CODE_W    = 4;
   localparam int RATIO_W   = 6;
   localparam int NUM_CODES = 15;
   localparam int SCAN_LAST = 13;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SLACK,
      ST_HIB,
      ST_LOB,
      ST_MAP,
      ST_CODE,
      ST_UPD,
      ST_NDIV,
      ST_NCHK,
      ST_VCO,
      ST_ROUND,
      ST_RATE
   } seq_t;

   // post-divider code to divide ratio; non-monotonic above code 9
   function automatic logic [RATIO_W-1:0] code_ratio(input logic [CODE_W-1:0] c);
      logic [RATIO_W-1:0] r;
      case (c)
         4'd0:    r = 6'd1;
         4'd1:    r = 6'd2;
         4'd2:    r = 6'd3;
         4'd3:    r = 6'd4;
         4'd4:    r = 6'd5;
         4'd5:    r = 6'd6;
         4'd6:    r = 6'd8;
         4'd7:    r = 6'd10;
         4'd8:    r = 6'd12;
         4'd9:    r = 6'd16;
         4'd10:   r = 6'd12;
         4'd11:   r = 6'd16;
         4'd12:   r = 6'd20;
         4'd13:   r = 6'd24;
         4'd14:   r = 6'd32;
         default: r = 6'd1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pll_div_unit.sv
module pll_div_unit #(
   parameter int W = 27
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         done,
   output logic [W-1:0] quot,
   output logic [W-1:0] rem
);

   localparam int CNT_W = $clog2(W + 1);

   logic [W-1:0]     rem_r, quo_r, den_r;
   logic [CNT_W-1:0] cnt;
   logic             running;
   logic [W:0]       shifted;
   logic             ge;
   logic [W-1:0]     diff;

   always_comb begin
      shifted = {rem_r, quo_r[W-1]};
      ge      = shifted >= {1'b0, den_r};
      diff    = shifted[W-1:0] - den_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_r   <= '0;
         quo_r   <= '0;
         den_r   <= '0;
         cnt     <= '0;
         running <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            rem_r   <= '0;
            quo_r   <= num;
            den_r   <= den;
            cnt     <= CNT_W'(W);
            running <= 1'b1;
         end else if (running) begin
            rem_r <= ge ? diff : shifted[W-1:0];
            quo_r <= {quo_r[W-2:0], ge};
            cnt   <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) begin
               running <= 1'b0;
               done    <= 1'b1;
            end
         end
      end
   end

   assign quot = quo_r;
   assign rem  = rem_r;

endmodule

// File: rtl/pll_code_map.sv
module pll_code_map
   import pll_search_pkg::*;
(
   input  logic [RATIO_W-1:0] bound,
   output logic [CODE_W-1:0]  code
);

   logic [SCAN_LAST:0] hit;

   for (genvar g = 0; g <= SCAN_LAST; g++) begin : g_cmp
      assign hit[g] = code_ratio(CODE_W'(g)) >= bound;
   end

   always_comb begin
      code = CODE_W'(NUM_CODES - 1);
      for (int i = SCAN_LAST; i >= 0; i--) begin
         if (hit[i]) code = CODE_W'(i);
      end
   end

endmodule

// File: rtl/pll_cand_judge.sv
module pll_cand_judge #(
   parameter int W = 27
) (
   input  logic [W-1:0] q,
   input  logic [W-1:0] vmin,
   input  logic [W-1:0] vmax,
   input  logic [W-1:0] goal,
   input  logic [W-1:0] best,
   output logic         in_win,
   output logic [W-1:0] delta,
   output logic         better
);

   always_comb begin
      in_win = (q >= vmin) && (q <= vmax);
      delta  = (q >= goal) ? (q - goal) : (goal - q);
      better = delta < best;
   end

endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
   import pll_search_pkg::*;
#(
   parameter int FREQ_W    = 12,
   parameter int VCO_MIN   = 1000,
   parameter int VCO_MAX   = 2064,
   parameter int U_MIN     = 12,
   parameter int U_MAX     = 38,
   parameter int M_MIN     = 1,
   parameter int M_MAX     = 255,
   parameter int N_MIN     = 8,
   parameter int N_MAX     = 255,
   parameter int DIVR_MIN  = 1,
   parameter int DIVR_MAX  = 32,
   parameter int SLACK_DEN = 50,
   localparam int M_W      = $clog2(M_MAX + 1),
   localparam int N_W      = $clog2(N_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FREQ_W-1:0] target_mhz,
   input  logic [FREQ_W-1:0] ref_mhz,
   output logic              busy,
   output logic              done,
   output logic [M_W-1:0]    m_out,
   output logic [N_W-1:0]    n_out,
   output logic [3:0]        pl_out,
   output logic              exact,
   output logic [FREQ_W+1:0] rate_mhz
);

   localparam int DIV_W = FREQ_W + 1 + RATIO_W + M_W;

   localparam logic [DIV_W-1:0] ONE_W   = DIV_W'(1);
   localparam logic [DIV_W-1:0] VMIN_W  = DIV_W'(VCO_MIN);
   localparam logic [DIV_W-1:0] VMAX_W  = DIV_W'(VCO_MAX);
   localparam logic [DIV_W-1:0] UMIN_W  = DIV_W'(U_MIN);
   localparam logic [DIV_W-1:0] UMAX_W  = DIV_W'(U_MAX);
   localparam logic [DIV_W-1:0] MMIN_W  = DIV_W'(M_MIN);
   localparam logic [DIV_W-1:0] MMAX_W  = DIV_W'(M_MAX);
   localparam logic [DIV_W-1:0] NMIN_W  = DIV_W'(N_MIN);
   localparam logic [DIV_W-1:0] NMAX_W  = DIV_W'(N_MAX);
   localparam logic [DIV_W-1:0] DRMIN_W = DIV_W'(DIVR_MIN);
   localparam logic [DIV_W-1:0] DRMAX_W = DIV_W'(DIVR_MAX);
   localparam logic [DIV_W-1:0] SLACK_W = DIV_W'(SLACK_DEN);

   if (VCO_MIN >= VCO_MAX) begin : g_bad_vco
      $error("VCO_MIN must be below VCO_MAX");
   end
   if (U_MIN > U_MAX || U_MIN < 1) begin : g_bad_u
      $error("update-rate window is empty");
   end
   if (M_MIN < 1 || M_MIN > M_MAX) begin : g_bad_m
      $error("M range invalid");
   end
   if (N_MIN > N_MAX) begin : g_bad_n
      $error("N range invalid");
   end
   if (DIVR_MIN < 1 || DIVR_MAX > 63 || DIVR_MIN > DIVR_MAX) begin : g_bad_divr
      $error("divide bound range invalid");
   end
   if (SLACK_DEN < 1) begin : g_bad_slack
      $error("SLACK_DEN must be positive");
   end

   seq_t               st;
   logic               go;
   logic [DIV_W-1:0]   dv_num, dv_den, dv_q, dv_r;
   logic               dv_done;

   logic [DIV_W-1:0]   tclk, tvco, maxv, ref_r, tv, vco;
   logic [DIV_W-1:0]   m_cur, n_cur, n_hi, best_d;
   logic [CODE_W-1:0]  pl, best_pl;
   logic [M_W-1:0]     best_m;
   logic [N_W-1:0]     best_n;
   logic [RATIO_W-1:0] hi_bnd, lo_bnd;
   logic [CODE_W-1:0]  hi_code, lo_code;
   logic [DIV_W-1:0]   ratio_w, ratio_best;
   logic               in_win, better;
   logic [DIV_W-1:0]   delta;

   function automatic logic [RATIO_W-1:0] clamp_div(input logic [DIV_W-1:0] v);
      if (v < DRMIN_W)      return RATIO_W'(DIVR_MIN);
      else if (v > DRMAX_W) return RATIO_W'(DIVR_MAX);
      else                  return v[RATIO_W-1:0];
   endfunction

   assign ratio_w    = DIV_W'(code_ratio(pl));
   assign ratio_best = DIV_W'(code_ratio(best_pl));

   pll_code_map u_lo_map (.bound(lo_bnd), .code(lo_code));
   pll_code_map u_hi_map (.bound(hi_bnd), .code(hi_code));

   pll_cand_judge #(.W(DIV_W)) u_judge (
      .q      (dv_q),
      .vmin   (VMIN_W),
      .vmax   (maxv),
      .goal   (tclk),
      .best   (best_d),
      .in_win (in_win),
      .delta  (delta),
      .better (better)
   );

   // operand selection for the shared divider
   always_comb begin
      dv_num = '0;
      dv_den = ONE_W;
      case (st)
         ST_SLACK: begin dv_num = tclk;               dv_den = SLACK_W;            end
         ST_HIB:   begin dv_num = maxv + tvco - ONE_W; dv_den = tvco;              end
         ST_LOB:   begin dv_num = VMIN_W;             dv_den = tvco;               end
         ST_UPD:   begin dv_num = ref_r;              dv_den = m_cur;              end
         ST_NDIV:  begin dv_num = tv * m_cur;         dv_den = ref_r;              end
         ST_VCO:   begin dv_num = ref_r * n_cur;      dv_den = m_cur;              end
         ST_ROUND: begin dv_num = vco + (ratio_w >> 1); dv_den = ratio_w;          end
         ST_RATE:  begin dv_num = ref_r * DIV_W'(best_n);
                         dv_den = DIV_W'(best_m) * ratio_best;                     end
         default:  begin dv_num = '0;                 dv_den = ONE_W;              end
      endcase
   end

   pll_div_unit #(.W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (go),
      .num   (dv_num),
      .den   (dv_den),
      .done  (dv_done),
      .quot  (dv_q),
      .rem   (dv_r)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         go       <= 1'b0;
         done     <= 1'b0;
         tclk     <= '0;
         tvco     <= '0;
         maxv     <= '0;
         ref_r    <= '0;
         tv       <= '0;
         vco      <= '0;
         m_cur    <= '0;
         n_cur    <= '0;
         n_hi     <= '0;
         best_d   <= '0;
         pl       <= '0;
         best_pl  <= '0;
         best_m   <= '0;
         best_n   <= '0;
         hi_bnd   <= '0;
         lo_bnd   <= '0;
         m_out    <= '0;
         n_out    <= '0;
         pl_out   <= '0;
         exact    <= 1'b0;
         rate_mhz <= '0;
      end else begin
         go   <= 1'b0;
         done <= 1'b0;
         case (st)
            ST_IDLE: if (start) begin
               tclk    <= DIV_W'(target_mhz) << 1;
               ref_r   <= DIV_W'(ref_mhz);
               best_m  <= M_W'(M_MAX);
               best_n  <= N_W'(N_MIN);
               best_pl <= CODE_W'(DIVR_MIN);
               best_d  <= '1;
               st      <= ST_SLACK;
               go      <= 1'b1;
            end
            ST_SLACK: if (dv_done) begin
               tvco <= tclk + dv_q;
               maxv <= (VMAX_W < tclk + dv_q) ? tclk + dv_q : VMAX_W;
               st   <= ST_HIB;
               go   <= 1'b1;
            end
            ST_HIB: if (dv_done) begin
               hi_bnd <= clamp_div(dv_q);
               st     <= ST_LOB;
               go     <= 1'b1;
            end
            ST_LOB: if (dv_done) begin
               lo_bnd <= clamp_div(dv_q);
               st     <= ST_MAP;
            end
            ST_MAP: begin
               pl <= lo_code;
               st <= ST_CODE;
            end
            ST_CODE: begin
               if (pl > hi_code) begin
                  st <= ST_RATE;
                  go <= 1'b1;
               end else begin
                  tv    <= tclk * ratio_w;
                  m_cur <= MMIN_W;
                  st    <= ST_UPD;
                  go    <= 1'b1;
               end
            end
            ST_UPD: if (dv_done) begin
               if (dv_q < UMIN_W) begin
                  pl <= pl + CODE_W'(1);
                  st <= ST_CODE;
               end else if (dv_q > UMAX_W) begin
                  if (m_cur >= MMAX_W) begin
                     pl <= pl + CODE_W'(1);
                     st <= ST_CODE;
                  end else begin
                     m_cur <= m_cur + ONE_W;
                     go    <= 1'b1;
                  end
               end else begin
                  st <= ST_NDIV;
                  go <= 1'b1;
               end
            end
            ST_NDIV: if (dv_done) begin
               if (dv_q > NMAX_W) begin
                  pl <= pl + CODE_W'(1);
                  st <= ST_CODE;
               end else begin
                  n_cur <= dv_q;
                  n_hi  <= dv_q + ((dv_r != '0) ? ONE_W : '0);
                  st    <= ST_NCHK;
               end
            end
            ST_NCHK: begin
               if (n_cur > n_hi || n_cur > NMAX_W) begin
                  if (m_cur >= MMAX_W) begin
                     pl <= pl + CODE_W'(1);
                     st <= ST_CODE;
                  end else begin
                     m_cur <= m_cur + ONE_W;
                     st    <= ST_UPD;
                     go    <= 1'b1;
                  end
               end else if (n_cur < NMIN_W) begin
                  n_cur <= n_cur + ONE_W;
               end else begin
                  st <= ST_VCO;
                  go <= 1'b1;
               end
            end
            ST_VCO: if (dv_done) begin
               if (in_win) begin
                  vco <= dv_q;
                  st  <= ST_ROUND;
                  go  <= 1'b1;
               end else begin
                  n_cur <= n_cur + ONE_W;
                  st    <= ST_NCHK;
               end
            end
            ST_ROUND: if (dv_done) begin
               if (better) begin
                  best_d  <= delta;
                  best_m  <= m_cur[M_W-1:0];
                  best_n  <= n_cur[N_W-1:0];
                  best_pl <= pl;
               end
               if (better && delta == '0) begin
                  st <= ST_RATE;
                  go <= 1'b1;
               end else begin
                  n_cur <= n_cur + ONE_W;
                  st    <= ST_NCHK;
               end
            end
            ST_RATE: if (dv_done) begin
               m_out    <= best_m;
               n_out    <= best_n;
               pl_out   <= best_pl;
               exact    <= (best_d == '0);
               rate_mhz <= dv_q[FREQ_W+2:1];
               done     <= 1'b1;
               st       <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st != ST_IDLE);

endmodule

// File: rtl/pll_search_chk.sv
module pll_search_chk #(
   parameter int M_W   = 8,
   parameter int N_W   = 8,
   parameter int N_MIN = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           busy,
   input logic           done,
   input logic           exact,
   input logic [M_W-1:0] m_out,
   input logic [N_W-1:0] n_out,
   input logic [3:0]     pl_out
);

   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R3
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R3
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(m_out) && $stable(n_out) && $stable(pl_out) && $stable(exact)));

   // R4
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pl_out <= 4'd14));

   // R9
   exact_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && exact) |-> (n_out >= N_W'(N_MIN) && m_out != '0));

endmodule

bind pll_coef_search pll_search_chk #(.M_W(M_W), .N_W(N_W), .N_MIN(N_MIN)) u_chk (.*);

// File: tb/pll_coef_search_test.sv
module pll_coef_search_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [11:0] target_mhz = '0;
   logic [11:0] ref_mhz = '0;
   logic        busy, done, exact;
   logic [7:0]  m_out, n_out;
   logic [3:0]  pl_out;
   logic [13:0] rate_mhz;

   int total = 0;
   int failed = 0;
   int g_m, g_n, g_pl, g_ex, g_rate;

   always #5 clk = ~clk;

   pll_coef_search uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .target_mhz(target_mhz), .ref_mhz(ref_mhz),
      .busy(busy), .done(done), .m_out(m_out), .n_out(n_out),
      .pl_out(pl_out), .exact(exact), .rate_mhz(rate_mhz)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         failed++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int ratio_of(input int c);
      int tbl[15] = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32};
      return tbl[c];
   endfunction

   function automatic int clamp32(input int v);
      if (v < 1) return 1;
      if (v > 32) return 32;
      return v;
   endfunction

   function automatic int first_code(input int b);
      for (int i = 0; i <= 13; i++) if (ratio_of(i) >= b) return i;
      return 14;
   endfunction

   // behavioural model of R5-R11
   task automatic model(input int tgt, input int rf,
                        output int om, output int on, output int opl,
                        output int oex, output int orate);
      int t, tvco, maxv, lo, hi, bd, r, tv, u, n1, n2, vco, lwv, d;
      bit fin;
      t = 2 * tgt;
      tvco = t + t / 50;
      maxv = (2064 < tvco) ? tvco : 2064;
      hi = first_code(clamp32((maxv + tvco - 1) / tvco));
      lo = first_code(clamp32(1000 / tvco));
      om = 255; on = 8; opl = 1; bd = 32'h7fffffff; fin = 0;
      for (int pl = lo; pl <= hi && !fin; pl++) begin
         r = ratio_of(pl);
         tv = t * r;
         for (int m = 1; m <= 255 && !fin; m++) begin
            u = rf / m;
            if (u < 12) break;
            if (u > 38) continue;
            n1 = tv * m / rf;
            n2 = (tv * m + rf - 1) / rf;
            if (n1 > 255) break;
            for (int n = n1; n <= n2 && !fin; n++) begin
               if (n < 8) continue;
               if (n > 255) break;
               vco = rf * n / m;
               if (vco >= 1000 && vco <= maxv) begin
                  lwv = (vco + r / 2) / r;
                  d = (lwv >= t) ? lwv - t : t - lwv;
                  if (d < bd) begin
                     bd = d; om = m; on = n; opl = pl;
                     if (d == 0) fin = 1;
                  end
               end
            end
         end
      end
      oex = (bd == 0) ? 1 : 0;
      orate = (rf * on / (om * ratio_of(opl))) / 2;
   endtask

   task automatic run(input int tgt, input int rf, input string req);
      int cyc = 0;
      @(negedge clk);
      target_mhz = 12'(tgt);
      ref_mhz = 12'(rf);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check({req, " R2 busy after start"}, int'(busy), 1);
      while (!done && cyc < 40000) begin
         @(negedge clk);
         cyc++;
      end
      check({req, " R3 done seen"}, int'(done), 1);
      check({req, " R3 busy low with done"}, int'(busy), 0);
      g_m = m_out; g_n = n_out; g_pl = pl_out; g_ex = exact; g_rate = rate_mhz;
      @(negedge clk);
      check({req, " R3 done one cycle"}, int'(done), 0);
   endtask

   task automatic expect_res(input string req, input int em, input int en,
                             input int epl, input int eex, input int erate);
      check({req, " m"}, g_m, em);
      check({req, " n"}, g_n, en);
      check({req, " pl"}, g_pl, epl);
      check({req, " exact"}, g_ex, eex);
      check({req, " rate"}, g_rate, erate);
   endtask

   task automatic t_reset();
      check("R1 busy", int'(busy), 0);
      check("R1 done", int'(done), 0);
      check("R1 m", int'(m_out), 0);
      check("R1 n", int'(n_out), 0);
      check("R1 pl", int'(pl_out), 0);
      check("R1 exact", int'(exact), 0);
      check("R1 rate", int'(rate_mhz), 0);
   endtask

   task automatic t_first_exact();
      run(72, 12, "R9");
      expect_res("R9 R4 R11 72@12", 1, 96, 6, 1, 72);
   endtask

   task automatic t_raised_max();
      run(1040, 13, "R5");
      expect_res("R5 1040@13", 1, 160, 0, 1, 1040);
   endtask

   task automatic t_last_code();
      run(18, 12, "R6");
      expect_res("R6 R4 18@12", 1, 96, 14, 1, 18);
   endtask

   task automatic t_skip_strict();
      run(400, 77, "R7");
      expect_res("R7 R9 400@77", 4, 83, 1, 0, 399);
   endtask

   task automatic t_inexact();
      run(852, 38, "R8");
      expect_res("R8 852@38", 1, 45, 0, 0, 855);
   endtask

   task automatic t_none();
      run(500, 10, "R10");
      expect_res("R10 500@10", 255, 8, 1, 0, 0);
   endtask

   task automatic t_hold();
      int m0 = m_out, n0 = n_out, p0 = pl_out;
      @(negedge clk);
      target_mhz = 12'd300;
      ref_mhz = 12'd20;
      repeat (20) @(negedge clk);
      check("R3 m held", int'(m_out), m0);
      check("R3 n held", int'(n_out), n0);
      check("R3 pl held", int'(pl_out), p0);
   endtask

   task automatic t_busy_ignore();
      int cyc = 0, dones = 0;
      @(negedge clk);
      target_mhz = 12'd72; ref_mhz = 12'd12; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (30) @(negedge clk);
      target_mhz = 12'd852; ref_mhz = 12'd38; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (cyc < 6000) begin
         if (done) begin
            dones++;
            if (dones == 1) begin
               g_m = m_out; g_n = n_out; g_pl = pl_out; g_ex = exact; g_rate = rate_mhz;
            end
         end
         @(negedge clk);
         cyc++;
      end
      check("R2 single done", dones, 1);
      check("R2 idle after", int'(busy), 0);
      expect_res("R2 first request kept", 1, 96, 6, 1, 72);
   endtask

   task automatic t_sweep();
      int tg[14] = '{100, 250, 400, 533, 612, 708, 804, 1000, 30, 9, 145, 300, 777, 900};
      int rf[14] = '{12, 19, 26, 38, 27, 13, 20, 12, 38, 26, 50, 33, 24, 15};
      int em, en, ep, ee, er;
      for (int i = 0; i < 14; i++) begin
         model(tg[i], rf[i], em, en, ep, ee, er);
         run(tg[i], rf[i], "R6 R7 R8 sweep");
         expect_res($sformatf("R6 R7 R8 R9 sweep %0d@%0d", tg[i], rf[i]), em, en, ep, ee, er);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_first_exact();
      t_hold();
      t_raised_max();
      t_last_code();
      t_skip_strict();
      t_inexact();
      t_none();
      t_busy_ignore();
      t_sweep();
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

endmodule